// File: doc/BRIEF.md
# MPU Region Permission Checker

This block decides whether one memory access may proceed under a protection-unit region scheme. A request carries a 32-bit address, an access kind (read, write or execute) and a flag telling whether the requester runs unprivileged. The checker scans a parameterised set of region descriptors supplied by an external register bank. It picks the highest-numbered usable region that covers the address, decodes that region's permission field for the requester's mode, and answers with permit or fault plus a fault status code. No address translation is done: the physical address is the input address.

When no region covers the address, the access either faults as a background fault or falls back to a fixed default map. The fault is taken for unprivileged requests and whenever the background enable is clear. The same default map applies whenever the protection unit is switched off. A request is captured on a valid strobe, and the answer appears one cycle later together with a single-cycle done pulse.

Each region has three words. The base word is a 32-bit base address. The size word holds the enable bit in bit 0, the size exponent S in bits [5:1] and eight subregion-disable bits in bits [15:8]. The access word holds the permission code in bits [10:8] and the execute-never bit in bit 12. Region n occupies slice n of each flattened bank port.

Top module: `mpu_perm_check`

## Requirements
- R1: While and after reset, before any request, respDone, respPermit and respFault are 0 and respStatus is 0.
- R2: A request presented with reqValid high at a clock edge is answered with respDone high for exactly the next cycle. The result outputs keep their values until the next request is answered.
- R3: With mpuEnable low, the default map decides every access. Read and write are always permitted. Execute is permitted for addresses 0x00000000–0x7FFFFFFF, and for 0xF0000000–0xFFFFFFFF only when highVectors is 1. All other execute requests are denied.
- R4: A region is considered only when size-word bit 0 is 1 and the size exponent S in bits [5:1] is nonzero. The region then spans 2^(S+1) bytes.
- R5: A region whose base is not a multiple of its span is skipped. An address hits when base <= address <= base + span - 1, and a region ending at 0xFFFFFFFF hits its last byte.
- R6: When several usable regions hit, the one with the highest index decides the access.
- R7: A region of 256 bytes or more has eight equal subregions. Subregion k is selected by (address - base) / (span/8), and size-word bit 8+k disables it. A hit in a disabled subregion makes the search continue at lower regions. Disable bits of smaller regions have no effect.
- R8: For an unprivileged request (reqUser = 1), the permission code in access-word bits [10:8] decodes as follows: 2 and 6 give read+execute, 3 gives read+write+execute, and 0, 1, 4, 5 and 7 give nothing.
- R9: For a privileged request, the permission code decodes as follows: 1, 2 and 3 give read+write+execute, 5 and 6 give read+execute, and 0, 4 and 7 give nothing.
- R10: Access-word bit 12 set on the deciding region removes execute permission.
- R11: With mpuEnable high and no usable hit, an unprivileged request or a request with bgEnable low faults with status 0x000. A privileged request with bgEnable high is decided by the default map of R3.
- R12: reqType encodes 0 = read, 1 = write, 2 = execute; code 3 is never permitted. A denied access that is not a background fault reports status 0x00D. A permitted access reports respFault = 0 and status 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request strobe; request fields sampled at this edge |
| reqAddr | input | 32 | Access address |
| reqType | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| reqUser | input | 1 | 1 = unprivileged requester |
| mpuEnable | input | 1 | Protection unit on |
| bgEnable | input | 1 | Privileged misses use the default map |
| highVectors | input | 1 | Allows execute in the top 256 MB under the default map |
| regionBase | input | NREG*32 | Base address words, region n in slice n |
| regionSize | input | NREG*16 | Size words: enable, exponent, subregion disables |
| regionAccess | input | NREG*16 | Access words: permission code, execute-never |
| respDone | output | 1 | One-cycle pulse when a result is presented |
| respPermit | output | 1 | Access permitted |
| respFault | output | 1 | Access denied |
| respStatus | output | 12 | Fault status code |

## Verification
The bench aims at subregion fall-through, where a disabled subregion of a high region must expose a lower region. A design that treats such a hit as a miss or as a denial would fault accesses that the lower region allows. It checks inclusive end bounds, including a region that ends at 0xFFFFFFFF. A 32-bit end computation would wrap there and lose the hit. Misaligned, zero-exponent and disabled regions must all be skipped, with the miss split into background fault and default map by privilege and bgEnable. It also sweeps all eight permission codes in both modes and all three access kinds, so a decode table with one wrong entry shows up as a permit/fault mismatch.

// File: rtl/mpu_perm_pkg.sv
package mpu_perm_pkg;
  localparam int ADDR_W = 32;
  localparam int SIZE_W = 16;
  localparam int ACC_W  = 16;
  localparam int STAT_W = 12;

  localparam logic [STAT_W-1:0] STAT_PERM = 12'h00D;
  localparam logic [STAT_W-1:0] STAT_BG   = 12'h000;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic exec;
    logic write;
    logic read;
  } perm_t;

  typedef struct packed {
    logic load;
    logic done;
  } ctrl_t;

  function automatic perm_t apDecode(input logic [2:0] ap, input logic user);
    perm_t p;
    p = '0;
    if (user) begin
      case (ap)
        3'd2, 3'd6: p = '{exec: 1'b1, write: 1'b0, read: 1'b1};
        3'd3:       p = '{exec: 1'b1, write: 1'b1, read: 1'b1};
        default:    p = '0;
      endcase
    end else begin
      case (ap)
        3'd1, 3'd2, 3'd3: p = '{exec: 1'b1, write: 1'b1, read: 1'b1};
        3'd5, 3'd6:       p = '{exec: 1'b1, write: 1'b0, read: 1'b1};
        default:          p = '0;
      endcase
    end
    return p;
  endfunction

  function automatic perm_t defaultMap(input logic [3:0] topNibble, input logic hiVec);
    perm_t p;
    p.read  = 1'b1;
    p.write = 1'b1;
    p.exec  = !topNibble[3] || ((topNibble == 4'hF) && hiVec);
    return p;
  endfunction
endpackage

// File: rtl/mpu_perm_ctrl.sv
module mpu_perm_ctrl
  import mpu_perm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  reqValid,
  output ctrl_t strobes
);
  logic doneQ;

  always_ff @(posedge clk) begin
    if (rst) doneQ <= 1'b0;
    else     doneQ <= reqValid;
  end

  assign strobes.load = reqValid && !rst;
  assign strobes.done = doneQ;

  p_done_follows_valid_r2: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> strobes.done);

  p_done_needs_valid_r2: assert property (@(posedge clk) disable iff (rst)
    strobes.done |-> $past(reqValid));
endmodule

// File: rtl/mpu_perm_datapath.sv
module mpu_perm_datapath
  import mpu_perm_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  ctrl_t                  strobes,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [1:0]             reqType,
  input  logic                   reqUser,
  input  logic                   mpuEnable,
  input  logic                   bgEnable,
  input  logic                   highVectors,
  input  logic [NREG*ADDR_W-1:0] regionBase,
  input  logic [NREG*SIZE_W-1:0] regionSize,
  input  logic [NREG*ACC_W-1:0]  regionAccess,
  output logic                   permitQ,
  output logic                   faultQ,
  output logic [STAT_W-1:0]      statusQ
);
  localparam int EXT_W = ADDR_W + 1;

  logic [NREG-1:0] regHit;

  for (genvar i = 0; i < NREG; i++) begin : g_region
    logic [ADDR_W-1:0] baseWord;
    logic [SIZE_W-1:0] sizeWord;
    logic [ACC_W-1:0]  accWord;
    logic [5:0]        span;
    logic [5:0]        subShift;
    logic [EXT_W-1:0]  mask;
    logic [EXT_W-1:0]  offset;
    logic [EXT_W-1:0]  subPos;
    logic [2:0]        subIdx;
    logic [7:0]        subDis;
    logic              usable;
    logic              aligned;
    logic              inRange;
    logic              subOff;
    logic              unusedBits;

    assign baseWord = regionBase[i*ADDR_W +: ADDR_W];
    assign sizeWord = regionSize[i*SIZE_W +: SIZE_W];
    assign accWord  = regionAccess[i*ACC_W +: ACC_W];
    assign subDis   = sizeWord[15:8];

    assign span     = {1'b0, sizeWord[5:1]} + 6'd1;
    assign mask     = (EXT_W'(1) << span) - EXT_W'(1);
    assign offset   = {1'b0, reqAddr} - {1'b0, baseWord};
    assign subShift = span - 6'd3;
    assign subPos   = offset >> subShift;
    assign subIdx   = subPos[2:0];

    assign usable   = sizeWord[0] && (sizeWord[5:1] != 5'd0);
    assign aligned  = (({1'b0, baseWord}) & mask) == '0;
    assign inRange  = (reqAddr >= baseWord) && (offset <= mask);
    assign subOff   = (span >= 6'd8) && subDis[subIdx];

    assign regHit[i] = usable && aligned && inRange && !subOff;

    assign unusedBits = ^{sizeWord[7:6], accWord[15:13], accWord[11], accWord[7:0],
                          subPos[EXT_W-1:3]};
  end

  logic       anyHit;
  logic [2:0] winAp;
  logic       winXn;

  always_comb begin
    anyHit = 1'b0;
    winAp  = '0;
    winXn  = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      if (regHit[i]) begin
        anyHit = 1'b1;
        winAp  = regionAccess[i*ACC_W + 8 +: 3];
        winXn  = regionAccess[i*ACC_W + 12];
      end
    end
  end

  perm_t             perm;
  logic              bgFault;
  logic              allowed;
  logic [STAT_W-1:0] nextStatus;

  always_comb begin
    bgFault = 1'b0;
    if (!mpuEnable) begin
      perm = defaultMap(reqAddr[ADDR_W-1 -: 4], highVectors);
    end else if (anyHit) begin
      perm = apDecode(winAp, reqUser);
      if (winXn) perm.exec = 1'b0;
    end else if ((NREG > 0) && (reqUser || !bgEnable)) begin
      bgFault = 1'b1;
      perm    = '0;
    end else begin
      perm = defaultMap(reqAddr[ADDR_W-1 -: 4], highVectors);
    end

    case (acc_e'(reqType))
      ACC_READ:  allowed = perm.read;
      ACC_WRITE: allowed = perm.write;
      ACC_EXEC:  allowed = perm.exec;
      default:   allowed = 1'b0;
    endcase

    if (allowed)      nextStatus = '0;
    else if (bgFault) nextStatus = STAT_BG;
    else              nextStatus = STAT_PERM;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      permitQ <= 1'b0;
      faultQ  <= 1'b0;
      statusQ <= '0;
    end else if (strobes.load) begin
      permitQ <= allowed;
      faultQ  <= !allowed;
      statusQ <= nextStatus;
    end
  end

  p_hold_between_r2: assert property (@(posedge clk) disable iff (rst)
    !strobes.load |=> $stable(permitQ) && $stable(faultQ) && $stable(statusQ));

  p_mpu_off_rw_r3: assert property (@(posedge clk) disable iff (rst)
    strobes.load && !mpuEnable && (reqType == 2'd0 || reqType == 2'd1) |=> permitQ);

  p_user_miss_fault_r11: assert property (@(posedge clk) disable iff (rst)
    strobes.load && mpuEnable && !anyHit && reqUser |=> faultQ && statusQ == STAT_BG);

  p_permit_clean_r12: assert property (@(posedge clk) disable iff (rst)
    permitQ |-> !faultQ && statusQ == '0);
endmodule

// File: rtl/mpu_perm_check.sv
module mpu_perm_check
  import mpu_perm_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reqValid,
  input  logic [31:0]            reqAddr,
  input  logic [1:0]             reqType,
  input  logic                   reqUser,
  input  logic                   mpuEnable,
  input  logic                   bgEnable,
  input  logic                   highVectors,
  input  logic [NREG*32-1:0]     regionBase,
  input  logic [NREG*16-1:0]     regionSize,
  input  logic [NREG*16-1:0]     regionAccess,
  output logic                   respDone,
  output logic                   respPermit,
  output logic                   respFault,
  output logic [11:0]            respStatus
);
  ctrl_t strobes;

  mpu_perm_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .strobes  (strobes)
  );

  mpu_perm_datapath #(.NREG(NREG)) u_dp (
    .clk          (clk),
    .rst          (rst),
    .strobes      (strobes),
    .reqAddr      (reqAddr),
    .reqType      (reqType),
    .reqUser      (reqUser),
    .mpuEnable    (mpuEnable),
    .bgEnable     (bgEnable),
    .highVectors  (highVectors),
    .regionBase   (regionBase),
    .regionSize   (regionSize),
    .regionAccess (regionAccess),
    .permitQ      (respPermit),
    .faultQ       (respFault),
    .statusQ      (respStatus)
  );

  assign respDone = strobes.done;
endmodule

// File: tb/mpu_perm_check_tb.sv
module mpu_perm_check_tb;
  localparam int NREG = 8;
  localparam int NVEC = 28;

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  acc;
    logic        user;
    logic        mpuOn;
    logic        bgOn;
    logic        hiVec;
    logic        expPermit;
    logic [11:0] expStatus;
    logic [7:0]  req;
  } vec_t;

  // Fields: addr, type(0 R,1 W,2 X), user, mpuOn, bgOn, hiVec, permit, status, requirement
  localparam vec_t VECS [NVEC] = '{
    '{32'h2000_0010, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 12'h000, 8'd6},  // R6 region 1 over region 0
    '{32'h2000_0010, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 12'h00D, 8'd6},  // R6
    '{32'h2000_0010, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 12'h00D, 8'd10}, // R10 execute-never
    '{32'h2000_0410, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 12'h000, 8'd7},  // R7 disabled subregion 2
    '{32'h2000_0210, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 12'h00D, 8'd7},  // R7 subregion 1 enabled
    '{32'h2000_0FFF, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 12'h00D, 8'd5},  // R5 last byte
    '{32'h2000_1000, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 12'h000, 8'd5},  // R5 one past end
    '{32'h3000_0040, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 12'h000, 8'd9},  // R9
    '{32'h3000_0040, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 12'h00D, 8'd8},  // R8
    '{32'h3000_0010, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 12'h000, 8'd11}, // R11 priv miss default map
    '{32'h3000_0010, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 12'h000, 8'd11}, // R11 user miss
    '{32'h4000_0090, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 8'd5},  // R5 misaligned skipped
    '{32'h5000_0000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 8'd4},  // R4 S zero
    '{32'h6000_0000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 8'd4},  // R4 not enabled
    '{32'hFFFF_FFFF, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 12'h000, 8'd5},  // R5 top of space
    '{32'hFFFF_FFFF, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 12'h000, 8'd9},  // R9
    '{32'hFFFF_FFFF, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 12'h00D, 8'd8},  // R8
    '{32'h7000_0010, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 12'h000, 8'd7},  // R7 small region ignores disables
    '{32'h7000_0010, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 12'h00D, 8'd9},  // R9 code 5
    '{32'h8000_0000, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 12'h00D, 8'd3},  // R3
    '{32'h1000_0000, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 12'h000, 8'd3},  // R3
    '{32'hF000_0000, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'h00D, 8'd3},  // R3 high vectors off
    '{32'hF000_0000, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 12'h000, 8'd3},  // R3 high vectors on
    '{32'hE000_0000, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 12'h000, 8'd3},  // R3
    '{32'hFFFF_FF00, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 12'h000, 8'd3},  // R3 regions ignored when off
    '{32'h9000_0000, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 12'h00D, 8'd11}, // R11
    '{32'h0800_0000, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 12'h000, 8'd11}, // R11
    '{32'h2000_8000, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 12'h00D, 8'd12}  // R12 reserved type
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reqValid = 1'b0;
  logic [31:0]       reqAddr = '0;
  logic [1:0]        reqType = '0;
  logic              reqUser = 1'b0;
  logic              mpuEnable = 1'b0;
  logic              bgEnable = 1'b0;
  logic              highVectors = 1'b0;
  logic [NREG*32-1:0] regionBase = '0;
  logic [NREG*16-1:0] regionSize = '0;
  logic [NREG*16-1:0] regionAccess = '0;
  logic              respDone;
  logic              respPermit;
  logic              respFault;
  logic [11:0]       respStatus;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mpu_perm_check #(.NREG(NREG)) u_dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqAddr(reqAddr), .reqType(reqType),
    .reqUser(reqUser), .mpuEnable(mpuEnable), .bgEnable(bgEnable),
    .highVectors(highVectors), .regionBase(regionBase), .regionSize(regionSize),
    .regionAccess(regionAccess), .respDone(respDone), .respPermit(respPermit),
    .respFault(respFault), .respStatus(respStatus)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL R2 watchdog: cycles=%0d expected < 100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic checkVal(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic setRegion(input int idx, input logic [31:0] base, input logic en,
                           input logic [4:0] sExp, input logic [7:0] subDis,
                           input logic [2:0] ap, input logic xn);
    regionBase[idx*32 +: 32]   = base;
    regionSize[idx*16 +: 16]   = {subDis, 2'b00, sExp, en};
    regionAccess[idx*16 +: 16] = {3'b000, xn, 1'b0, ap, 8'h00};
  endtask

  task automatic doAccess(input logic [31:0] addr, input logic [1:0] acc, input logic user,
                          input logic mpuOn, input logic bgOn, input logic hiVec);
    @(negedge clk);
    reqAddr = addr; reqType = acc; reqUser = user;
    mpuEnable = mpuOn; bgEnable = bgOn; highVectors = hiVec;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  function automatic logic [2:0] expAp(input int ap, input int user);
    // returns {exec, write, read}
    if (user != 0) begin
      case (ap)
        2, 6:    return 3'b101;
        3:       return 3'b111;
        default: return 3'b000;
      endcase
    end else begin
      case (ap)
        1, 2, 3: return 3'b111;
        5, 6:    return 3'b101;
        default: return 3'b000;
      endcase
    end
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checkVal("R1", "done in reset", int'(respDone), 0);
    checkVal("R1", "permit in reset", int'(respPermit), 0);
    rst = 1'b0;
    @(negedge clk);
    checkVal("R1", "done after reset", int'(respDone), 0);
    checkVal("R1", "fault after reset", int'(respFault), 0);
    checkVal("R1", "status after reset", int'(respStatus), 0);

    setRegion(0, 32'h2000_0000, 1'b1, 5'd15, 8'h00, 3'd3, 1'b0);
    setRegion(1, 32'h2000_0000, 1'b1, 5'd11, 8'h04, 3'd6, 1'b1);
    setRegion(2, 32'h3000_0000, 1'b1, 5'd7,  8'h01, 3'd1, 1'b0);
    setRegion(3, 32'h4000_0080, 1'b1, 5'd7,  8'h00, 3'd3, 1'b0);
    setRegion(4, 32'h5000_0000, 1'b1, 5'd0,  8'h00, 3'd3, 1'b0);
    setRegion(5, 32'h6000_0000, 1'b0, 5'd7,  8'h00, 3'd3, 1'b0);
    setRegion(6, 32'hFFFF_FF00, 1'b1, 5'd7,  8'h00, 3'd2, 1'b0);
    setRegion(7, 32'h7000_0000, 1'b1, 5'd6,  8'hFF, 3'd5, 1'b0);

    for (int v = 0; v < NVEC; v++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[v].req);
      doAccess(VECS[v].addr, VECS[v].acc, VECS[v].user, VECS[v].mpuOn,
               VECS[v].bgOn, VECS[v].hiVec);
      checkVal("R2", $sformatf("done vec %0d", v), int'(respDone), 1);
      checkVal(tag, $sformatf("permit vec %0d", v), int'(respPermit), int'(VECS[v].expPermit));
      checkVal(tag, $sformatf("fault vec %0d", v), int'(respFault), int'(!VECS[v].expPermit));
      checkVal(tag, $sformatf("status vec %0d", v), int'(respStatus), int'(VECS[v].expStatus));
    end

    // R2 done is a single pulse and the result holds afterwards
    doAccess(32'h2000_0010, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0);
    reqAddr = 32'h2000_1000;
    @(negedge clk);
    checkVal("R2", "done drops", int'(respDone), 0);
    checkVal("R2", "fault held", int'(respFault), 1);
    checkVal("R2", "status held", int'(respStatus), 'h00D);

    // R8 / R9 full permission sweep on region 0 only
    for (int ap = 0; ap < 8; ap++) begin
      setRegion(0, 32'h2000_0000, 1'b1, 5'd15, 8'h00, 3'(ap), 1'b0);
      for (int u = 0; u < 2; u++) begin
        for (int t = 0; t < 3; t++) begin
          logic [2:0] p;
          p = expAp(ap, u);
          doAccess(32'h2000_8000, 2'(t), 1'(u), 1'b1, 1'b1, 1'b0);
          checkVal(u != 0 ? "R8" : "R9", $sformatf("permit ap=%0d type=%0d", ap, t),
                   int'(respPermit), int'(p[t]));
          checkVal("R12", $sformatf("status ap=%0d user=%0d type=%0d", ap, u, t),
                   int'(respStatus), p[t] ? 0 : 'h00D);
        end
      end
    end

    // R10 execute-never on a full-access region
    setRegion(0, 32'h2000_0000, 1'b1, 5'd15, 8'h00, 3'd3, 1'b1);
    doAccess(32'h2000_8000, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0);
    checkVal("R10", "xn exec", int'(respPermit), 0);
    doAccess(32'h2000_8000, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0);
    checkVal("R10", "xn read", int'(respPermit), 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule